// File: doc/BRIEF.md
# DMA Copy Engine

This block performs one memory-to-memory copy for a DMA channel once the surrounding register block asks it to start. At the start request it checks the descriptor it is given: a read size, a write size, a repeat option, a byte count, a source and a destination address. A descriptor that fails the checks is refused at once with an error status, and no memory access is made.

An accepted descriptor is copied into execution registers, which software can read through the outputs of this block. The copy then runs as a series of equal beats. Each beat reads from the current source address over a request/acknowledge port, then writes the same bytes to the current destination address over a second request/acknowledge port. Both ports carry a 64-byte data bus. The execution counters advance after every beat. When the count runs out, the block signals completion, and if repeat was requested it restores the starting values.

Top module: `pdma_copy_engine`

## Requirements
- R1: A start with a byte count of zero is refused. One cycle after the start, the state code is 2 (error) and `err_o` is 1. No read request is issued.
- R2: A start whose write size field differs from its read size field is refused in the same way as in R1.
- R3: The beat is 2^min(size,6) bytes, so it is never more than 64 bytes. During a write, `wr_be_o` bit i is 1 exactly when i is less than the beat length, and the low beat bytes of `wr_data_o` match the bytes read.
- R4: A start whose byte count is not a whole multiple of the beat length is refused as in R1, and no data moves.
- R5: An accepted start clears `done_o` and `err_o`. It loads the count, source and destination into the execution outputs, and one cycle later shows state code 1 (started) with `busy_o` high.
- R6: A beat holds `rd_req_o` with `rd_addr_o` equal to the execution source until `rd_ack_i` arrives. It then holds `wr_req_o` with `wr_addr_o` equal to the execution destination until `wr_ack_i` arrives. The two requests are never high together.
- R7: After each write acknowledge, the execution source and destination each grow by the beat length, and the execution count shrinks by the beat length.
- R8: After the write acknowledge of the last beat, the state code is 3 (done) for one cycle and `done_o` is set. Without repeat, the execution count is then 0 and both addresses point just past their ranges.
- R9: With the repeat option set, the execution count, source and destination return to their starting values when the transfer completes.
- R10: A start that arrives while a transfer is in progress is ignored. The running transfer keeps its addresses, count and number of beats.
- R11: The state code is 0 when idle, 1 while transferring, 2 for error and 3 for done. The error and done codes each last one cycle, and the next cycle shows 0.
- R12: A refused start sets `err_o` but leaves `done_o` as it was. Both flags hold their value until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request pulse |
| cfg_rd_size_i | input | SZ_W | Read size, log2 of bytes |
| cfg_wr_size_i | input | SZ_W | Write size, log2 of bytes |
| cfg_repeat_i | input | 1 | Restore execution registers at completion |
| next_bytes_i | input | CNT_W | Byte count of the descriptor |
| next_src_i | input | ADDR_W | Source address of the descriptor |
| next_dst_i | input | ADDR_W | Destination address of the descriptor |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | 8*BUS_BYTES | Read data |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | 8*BUS_BYTES | Write data |
| wr_be_o | output | BUS_BYTES | Write byte enables |
| wr_ack_i | input | 1 | Write acknowledge |
| state_o | output | 2 | Channel state code |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Done status |
| err_o | output | 1 | Error status |
| exec_bytes_o | output | CNT_W | Remaining byte count |
| exec_src_o | output | ADDR_W | Current source address |
| exec_dst_o | output | ADDR_W | Current destination address |

## Verification
The start decision takes one register stage. Both the started code with freshly loaded execution values and the error code are therefore due at the first falling edge after the rising edge that samples `start_i`. The bench drives inputs and samples outputs on falling edges, so every check lands one clock after its stimulus. Memory requests are answered one cycle after they appear, and each address and data value is checked in the first cycle its request is up. Completion is found by scanning for the done code. The bench then checks the counters in that cycle and confirms the idle code one cycle later.

// File: rtl/pdma_copy_pkg.sv
package pdma_copy_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_READ,
      PH_WRITE,
      PH_DONE,
      PH_ERR
   } phase_e;

   localparam logic [1:0] SC_IDLE    = 2'd0;
   localparam logic [1:0] SC_STARTED = 2'd1;
   localparam logic [1:0] SC_ERROR   = 2'd2;
   localparam logic [1:0] SC_DONE    = 2'd3;
endpackage

// File: rtl/pdma_desc_check.sv
module pdma_desc_check #(
   parameter int CNT_W   = 32,
   parameter int SZ_W    = 4,
   parameter int MAX_LOG = 6,
   localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
   input  logic [SZ_W-1:0]  rd_size,
   input  logic [SZ_W-1:0]  wr_size,
   input  logic [CNT_W-1:0] bytes,
   output logic [LOG_W-1:0] beat_log,
   output logic [CNT_W-1:0] beat_bytes,
   output logic             desc_ok
);
   logic [CNT_W-1:0] rem;
   logic             sizes_match;
   logic             nonzero;

   // clamp the beat exponent to the bus width
   always_comb begin
      if (wr_size > SZ_W'(MAX_LOG)) beat_log = LOG_W'(MAX_LOG);
      else                          beat_log = wr_size[LOG_W-1:0];
   end

   assign beat_bytes  = CNT_W'(1) << beat_log;
   assign rem         = bytes & (beat_bytes - CNT_W'(1));
   assign sizes_match = (rd_size == wr_size);
   assign nonzero     = (bytes != '0);
   assign desc_ok     = nonzero && sizes_match && (rem == '0);

   // R3: beat length never exceeds the bus
   always_comb begin
      a_r3_beat_cap: assert (beat_bytes <= CNT_W'(1 << MAX_LOG));
   end
endmodule

// File: rtl/pdma_be_gen.sv
module pdma_be_gen #(
   parameter int BUS_BYTES = 64,
   parameter int LOG_W     = 3,
   localparam int CW       = $clog2(BUS_BYTES) + 1
) (
   input  logic [LOG_W-1:0]     beat_log,
   output logic [BUS_BYTES-1:0] be
);
   logic [CW-1:0] beat_cnt;
   assign beat_cnt = CW'(1) << beat_log;

   for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
      assign be[g] = (CW'(g) < beat_cnt);
   end
endmodule

// File: rtl/pdma_xfer_seq.sv
module pdma_xfer_seq
   import pdma_copy_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 32,
   parameter int BUS_BYTES = 64,
   parameter int LOG_W     = 3,
   localparam int DW       = 8 * BUS_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              desc_ok,
   input  logic [LOG_W-1:0]  beat_log,
   input  logic [CNT_W-1:0]  beat_bytes,
   input  logic              cfg_repeat,
   input  logic [CNT_W-1:0]  next_bytes,
   input  logic [ADDR_W-1:0] next_src,
   input  logic [ADDR_W-1:0] next_dst,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DW-1:0]     rd_data,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DW-1:0]     wr_data,
   input  logic              wr_ack,
   output logic [LOG_W-1:0]  cur_log,
   output logic [1:0]        state_code,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [CNT_W-1:0]  exec_bytes,
   output logic [ADDR_W-1:0] exec_src,
   output logic [ADDR_W-1:0] exec_dst
);
   phase_e            phase;
   logic [CNT_W-1:0]  x_beat;
   logic              x_repeat;
   logic [CNT_W-1:0]  st_bytes;
   logic [ADDR_W-1:0] st_src;
   logic [ADDR_W-1:0] st_dst;
   logic [DW-1:0]     data_q;
   logic              last_beat;
   logic [ADDR_W-1:0] step;

   assign last_beat = (exec_bytes == x_beat);
   assign step      = ADDR_W'(x_beat);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         done       <= 1'b0;
         err        <= 1'b0;
         exec_bytes <= '0;
         exec_src   <= '0;
         exec_dst   <= '0;
         st_bytes   <= '0;
         st_src     <= '0;
         st_dst     <= '0;
         x_beat     <= '0;
         x_repeat   <= 1'b0;
         cur_log    <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  if (desc_ok) begin
                     phase      <= PH_READ;
                     done       <= 1'b0;
                     err        <= 1'b0;
                     exec_bytes <= next_bytes;
                     exec_src   <= next_src;
                     exec_dst   <= next_dst;
                     st_bytes   <= next_bytes;
                     st_src     <= next_src;
                     st_dst     <= next_dst;
                     x_beat     <= beat_bytes;
                     x_repeat   <= cfg_repeat;
                     cur_log    <= beat_log;
                  end else begin
                     phase <= PH_ERR;
                     err   <= 1'b1;
                  end
               end
            end
            PH_READ: begin
               if (rd_ack) phase <= PH_WRITE;
            end
            PH_WRITE: begin
               if (wr_ack) begin
                  if (last_beat) begin
                     phase <= PH_DONE;
                     done  <= 1'b1;
                     if (x_repeat) begin
                        exec_bytes <= st_bytes;
                        exec_src   <= st_src;
                        exec_dst   <= st_dst;
                     end else begin
                        exec_bytes <= '0;
                        exec_src   <= exec_src + step;
                        exec_dst   <= exec_dst + step;
                     end
                  end else begin
                     phase      <= PH_READ;
                     exec_bytes <= exec_bytes - x_beat;
                     exec_src   <= exec_src + step;
                     exec_dst   <= exec_dst + step;
                  end
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // beat data holding register, no reset needed
   always_ff @(posedge clk) begin
      if (phase == PH_READ && rd_ack) data_q <= rd_data;
   end

   always_comb begin
      case (phase)
         PH_IDLE:  state_code = SC_IDLE;
         PH_READ,
         PH_WRITE: state_code = SC_STARTED;
         PH_ERR:   state_code = SC_ERROR;
         default:  state_code = SC_DONE;
      endcase
   end

   assign busy    = (phase == PH_READ) || (phase == PH_WRITE);
   assign rd_req  = (phase == PH_READ);
   assign rd_addr = exec_src;
   assign wr_req  = (phase == PH_WRITE);
   assign wr_addr = exec_dst;
   assign wr_data = data_q;

   // R6: the two memory requests never overlap
   a_r6_one_request: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req));

   // R1 R2 R4: a refused descriptor goes straight to error
   a_r1_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && start && !desc_ok) |=> (phase == PH_ERR && err && !rd_req));

   // R5: an accepted start clears status and loads the count
   a_r5_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && start && desc_ok) |=>
         (phase == PH_READ && !done && !err && exec_bytes == $past(next_bytes)));

   // R7: counters step by one beat on each non-final write acknowledge
   a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WRITE && wr_ack && !last_beat) |=>
         (exec_bytes == $past(exec_bytes) - x_beat && exec_src == $past(exec_src) + step));

   // R8: final write acknowledge leads to done
   a_r8_done: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WRITE && wr_ack && last_beat) |=> (phase == PH_DONE && done && !err));

   // R10: a start while busy leaves the running transfer alone
   a_r10_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !(phase == PH_WRITE && wr_ack)) |=>
         ($stable(exec_bytes) && $stable(exec_src) && $stable(cur_log)));

   // R11: error and done codes last one cycle
   a_r11_transient: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DONE || phase == PH_ERR) |=> (phase == PH_IDLE));
endmodule

// File: rtl/pdma_copy_engine.sv
module pdma_copy_engine #(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 32,
   parameter int BUS_BYTES = 64,
   parameter int SZ_W      = 4,
   parameter int MAX_LOG   = 6,
   localparam int LOG_W    = $clog2(MAX_LOG + 1),
   localparam int DW       = 8 * BUS_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [SZ_W-1:0]   cfg_rd_size_i,
   input  logic [SZ_W-1:0]   cfg_wr_size_i,
   input  logic              cfg_repeat_i,
   input  logic [CNT_W-1:0]  next_bytes_i,
   input  logic [ADDR_W-1:0] next_src_i,
   input  logic [ADDR_W-1:0] next_dst_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [DW-1:0]     rd_data_i,
   output logic              wr_req_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DW-1:0]     wr_data_o,
   output logic [BUS_BYTES-1:0] wr_be_o,
   input  logic              wr_ack_i,
   output logic [1:0]        state_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [CNT_W-1:0]  exec_bytes_o,
   output logic [ADDR_W-1:0] exec_src_o,
   output logic [ADDR_W-1:0] exec_dst_o
);
   // elaboration-time parameter checks
   if (BUS_BYTES != (1 << MAX_LOG)) begin : g_bad_bus
      $error("BUS_BYTES must equal 2**MAX_LOG");
   end
   if (CNT_W <= MAX_LOG) begin : g_bad_cnt
      $error("CNT_W must exceed MAX_LOG");
   end
   if ((1 << SZ_W) <= MAX_LOG) begin : g_bad_sz
      $error("SZ_W too narrow for MAX_LOG");
   end

   logic [LOG_W-1:0] chk_log;
   logic [CNT_W-1:0] chk_bytes;
   logic             chk_ok;
   logic [LOG_W-1:0] run_log;

   pdma_desc_check #(
      .CNT_W   (CNT_W),
      .SZ_W    (SZ_W),
      .MAX_LOG (MAX_LOG)
   ) u_check (
      .rd_size    (cfg_rd_size_i),
      .wr_size    (cfg_wr_size_i),
      .bytes      (next_bytes_i),
      .beat_log   (chk_log),
      .beat_bytes (chk_bytes),
      .desc_ok    (chk_ok)
   );

   pdma_xfer_seq #(
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .BUS_BYTES (BUS_BYTES),
      .LOG_W     (LOG_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_i),
      .desc_ok    (chk_ok),
      .beat_log   (chk_log),
      .beat_bytes (chk_bytes),
      .cfg_repeat (cfg_repeat_i),
      .next_bytes (next_bytes_i),
      .next_src   (next_src_i),
      .next_dst   (next_dst_i),
      .rd_req     (rd_req_o),
      .rd_addr    (rd_addr_o),
      .rd_ack     (rd_ack_i),
      .rd_data    (rd_data_i),
      .wr_req     (wr_req_o),
      .wr_addr    (wr_addr_o),
      .wr_data    (wr_data_o),
      .wr_ack     (wr_ack_i),
      .cur_log    (run_log),
      .state_code (state_o),
      .busy       (busy_o),
      .done       (done_o),
      .err        (err_o),
      .exec_bytes (exec_bytes_o),
      .exec_src   (exec_src_o),
      .exec_dst   (exec_dst_o)
   );

   pdma_be_gen #(
      .BUS_BYTES (BUS_BYTES),
      .LOG_W     (LOG_W)
   ) u_be (
      .beat_log (run_log),
      .be       (wr_be_o)
   );
endmodule

// File: tb/tb_pdma_copy_engine.sv
`timescale 1ns/1ps
module tb_pdma_copy_engine;
   typedef struct packed {
      logic [3:0]  rs;
      logic [3:0]  ws;
      logic        rep;
      logic [31:0] bytes;
      logic [31:0] src;
      logic [31:0] dst;
      logic        bad;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{4'd2, 4'd2, 1'b0, 32'd16,  32'h1000, 32'h2000, 1'b0},
      '{4'd0, 4'd0, 1'b0, 32'd3,   32'h0010, 32'h0020, 1'b0},
      '{4'd6, 4'd6, 1'b0, 32'd128, 32'h3000, 32'h4000, 1'b0},
      '{4'd9, 4'd9, 1'b0, 32'd192, 32'h7000, 32'h8000, 1'b0},
      '{4'd3, 4'd3, 1'b0, 32'd0,   32'h0A00, 32'h0B00, 1'b1},
      '{4'd3, 4'd2, 1'b0, 32'd16,  32'h0A00, 32'h0B00, 1'b1},
      '{4'd3, 4'd3, 1'b0, 32'd12,  32'h0A00, 32'h0B00, 1'b1},
      '{4'd1, 4'd1, 1'b1, 32'd6,   32'h0300, 32'h0400, 1'b0},
      '{4'd4, 4'd4, 1'b0, 32'd48,  32'hC000, 32'hD000, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [3:0] cfg_rd_size_i = '0, cfg_wr_size_i = '0;
   logic cfg_repeat_i = 1'b0;
   logic [31:0] next_bytes_i = '0, next_src_i = '0, next_dst_i = '0;
   logic rd_req_o, wr_req_o, busy_o, done_o, err_o;
   logic [31:0] rd_addr_o, wr_addr_o, exec_bytes_o, exec_src_o, exec_dst_o;
   logic rd_ack_i = 1'b0, wr_ack_i = 1'b0;
   logic [511:0] rd_data_i = '0, wr_data_o;
   logic [63:0] wr_be_o;
   logic [1:0] state_o;

   always #4 clk = ~clk;

   pdma_copy_engine dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cfg_rd_size_i(cfg_rd_size_i), .cfg_wr_size_i(cfg_wr_size_i),
      .cfg_repeat_i(cfg_repeat_i), .next_bytes_i(next_bytes_i),
      .next_src_i(next_src_i), .next_dst_i(next_dst_i),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
      .rd_data_i(rd_data_i), .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .wr_be_o(wr_be_o), .wr_ack_i(wr_ack_i),
      .state_o(state_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
      .exec_bytes_o(exec_bytes_o), .exec_src_o(exec_src_o), .exec_dst_o(exec_dst_o)
   );

   int n_chk = 0, n_bad = 0;
   int beats = 0, reads = 0, overlaps = 0;
   logic [31:0] cur_src = '0, cur_dst = '0, cur_beat = 32'd1;
   logic [31:0] exp_bytes = '0, exp_src = '0, exp_dst = '0;
   logic exp_done = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input logic [31:0] a);
      return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'hA5;
   endfunction

   function automatic logic [511:0] mk(input logic [31:0] a);
      logic [511:0] d;
      for (int i = 0; i < 64; i++) d[8*i +: 8] = pat(a + 32'(i));
      return d;
   endfunction

   function automatic logic [63:0] lane_mask(input logic [31:0] b);
      if (b >= 32'd64) return '1;
      return (64'd1 << b) - 64'd1;
   endfunction

   function automatic logic [31:0] beat_of(input logic [3:0] ws);
      return 32'd1 << ((ws > 4'd6) ? 4'd6 : ws);
   endfunction

   // memory responder: acknowledges one cycle after a request appears
   always @(negedge clk) begin
      if (!rst_n) begin
         rd_ack_i <= 1'b0;
         wr_ack_i <= 1'b0;
      end else begin
         if (rd_req_o && wr_req_o) overlaps++;
         if (rd_req_o && !rd_ack_i) begin
            check(rd_addr_o == cur_src, "R6 read address", 64'(rd_addr_o), 64'(cur_src));
            rd_data_i <= mk(rd_addr_o);
            rd_ack_i  <= 1'b1;
            reads++;
         end else begin
            rd_ack_i <= 1'b0;
         end
         if (wr_req_o && !wr_ack_i) begin
            logic [511:0] bm;
            int diff;
            for (int i = 0; i < 64; i++) bm[8*i +: 8] = {8{wr_be_o[i]}};
            diff = 0;
            for (int i = 0; i < 64; i++)
               if (wr_be_o[i] && (wr_data_o[8*i +: 8] != pat(cur_src + 32'(i)))) diff++;
            check(wr_addr_o == cur_dst, "R6 write address", 64'(wr_addr_o), 64'(cur_dst));
            check(wr_be_o == lane_mask(cur_beat), "R3 byte enables", wr_be_o, lane_mask(cur_beat));
            check(diff == 0, "R3 write data bytes", 64'(diff), 64'd0);
            cur_src  = cur_src + cur_beat;
            cur_dst  = cur_dst + cur_beat;
            beats++;
            wr_ack_i <= 1'b1;
         end else begin
            wr_ack_i <= 1'b0;
         end
      end
   end

   task automatic launch(input vec_t v);
      @(negedge clk);
      cfg_rd_size_i = v.rs;
      cfg_wr_size_i = v.ws;
      cfg_repeat_i  = v.rep;
      next_bytes_i  = v.bytes;
      next_src_i    = v.src;
      next_dst_i    = v.dst;
      cur_src  = v.src;
      cur_dst  = v.dst;
      cur_beat = beat_of(v.ws);
      beats = 0;
      reads = 0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic finish_good(input vec_t v, input logic [31:0] nbeats);
      bit seen;
      seen = 1'b0;
      for (int k = 0; k < 3000 && !seen; k++) begin
         if (state_o == 2'd3) seen = 1'b1;
         else @(negedge clk);
      end
      check(seen, "R8 done code reached", 64'(state_o), 64'd3);
      check(done_o && !err_o, "R8 done flag", {62'd0, done_o, err_o}, 64'd2);
      check(beats == int'(nbeats), "R7 beat count", 64'(beats), 64'(nbeats));
      if (v.rep) begin
         exp_bytes = v.bytes; exp_src = v.src; exp_dst = v.dst;
      end else begin
         exp_bytes = 0; exp_src = v.src + v.bytes; exp_dst = v.dst + v.bytes;
      end
      check(exec_bytes_o == exp_bytes, v.rep ? "R9 reload count" : "R8 final count",
            64'(exec_bytes_o), 64'(exp_bytes));
      check(exec_src_o == exp_src && exec_dst_o == exp_dst, v.rep ? "R9 reload addresses" : "R7 final addresses",
            {exec_src_o, exec_dst_o}, {exp_src, exp_dst});
      exp_done = 1'b1;
      @(negedge clk);
      check(state_o == 2'd0 && !busy_o, "R11 idle after done", 64'(state_o), 64'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check(state_o == 2'd0 && !busy_o && !done_o && !err_o, "R11 reset state",
            {60'd0, state_o, done_o, err_o}, 64'd0);
      check(!rd_req_o && !wr_req_o && exec_bytes_o == 0 && exec_src_o == 0, "R11 reset outputs",
            {rd_req_o, wr_req_o, 30'd0, exec_bytes_o}, 64'd0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         launch(VEC[i]);
         if (VEC[i].bad) begin
            string tg;
            tg = (VEC[i].bytes == 0) ? "R1 zero count" :
                 (VEC[i].rs != VEC[i].ws) ? "R2 size mismatch" : "R4 uneven count";
            check(state_o == 2'd2 && err_o && !busy_o, tg, {61'd0, state_o, err_o}, {61'd0, 2'd2, 1'b1});
            check(done_o == exp_done, "R12 done kept on refusal", 64'(done_o), 64'(exp_done));
            check(exec_bytes_o == exp_bytes && exec_src_o == exp_src, "R4 exec unchanged",
                  {exec_bytes_o, exec_src_o}, {exp_bytes, exp_src});
            @(negedge clk);
            check(state_o == 2'd0, "R11 idle after error", 64'(state_o), 64'd0);
            check(reads == 0 && beats == 0, "R1 no memory access", 64'(reads), 64'd0);
         end else begin
            check(state_o == 2'd1 && busy_o && !done_o && !err_o, "R5 start status",
                  {59'd0, state_o, busy_o, done_o, err_o}, {59'd0, 2'd1, 1'b1, 2'b00});
            check(exec_bytes_o == VEC[i].bytes && exec_src_o == VEC[i].src && exec_dst_o == VEC[i].dst,
                  "R5 exec load", {exec_bytes_o, exec_src_o}, {VEC[i].bytes, VEC[i].src});
            finish_good(VEC[i], VEC[i].bytes / beat_of(VEC[i].ws));
         end
      end

      // R10: a second start while busy is ignored
      begin
         vec_t a, b;
         a = '{4'd2, 4'd2, 1'b0, 32'd32, 32'h5000, 32'h6000, 1'b0};
         b = '{4'd0, 4'd0, 1'b1, 32'd8,  32'h9000, 32'h9800, 1'b0};
         launch(a);
         cfg_rd_size_i = b.rs; cfg_wr_size_i = b.ws; cfg_repeat_i = b.rep;
         next_bytes_i = b.bytes; next_src_i = b.src; next_dst_i = b.dst;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         check(busy_o && exec_src_o != b.src, "R10 busy start ignored", 64'(exec_src_o), 64'h5000);
         finish_good(a, 32'd8);
      end

      check(overlaps == 0, "R6 requests exclusive", 64'(overlaps), 64'd0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule